// File: doc/BRIEF.md
# Authenticated Scratchpad with Transfer Status

This block is the staging buffer in front of a protected nonvolatile array. A byte-level front end hands it a write command: a two-byte target address, then up to eight data bytes, then an end marker that says how many stray bits followed the last whole byte. The block aligns the address to an 8-byte block, stores the data, and keeps a status byte. The status byte has a partial flag, which records whether the last write ended cleanly, and an accepted flag, which records whether the current contents have already reached memory.

A read request streams the two address bytes back, then the status byte, then the eight buffer bytes. A copy request moves the whole buffer into the addressed block of memory in one write-port cycle. The copy happens only when an external authorization-match input is high during the request. One designated page is write-to-zero: a copy there can only clear bits.

Top module: `auth_scratchpad`

## Requirements
- R1: The stored target-address low byte always has its low 3 bits at zero, whatever value was sent. The upper bits are kept as sent.
- R2: In the status byte, bits 6, 4, 3 and 2..0 always read 1. Bit 7 is the accepted flag and bit 5 is the partial flag.
- R3: The partial flag is 1 after reset. A write that ends with a nonzero bit residue sets it to 1. A write that ends with residue 0 clears it.
- R4: The accepted flag is 0 after reset and is cleared by the start of any write. It is set only by an authorized copy.
- R5: After a read start, successive read requests return, one cycle after each request: address low byte, address high byte, status byte, buffer bytes 0 to 7, and then 0xFF for every further request.
- R6: Data bytes that were fully received are stored in order from buffer byte 0. A truncated final byte never arrives as a byte and leaves the buffer untouched. Data bytes beyond the eighth are ignored.
- R7: A copy request with the authorization input low writes nothing and leaves the accepted flag unchanged. With the input high, the write port fires for exactly one cycle, in the cycle after the request.
- R8: A copy into the write-to-zero page writes (old contents AND buffer) to memory.
- R9: A copy writes the block at index (target address >> 3), with buffer byte k on write-data bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_start_i | input | 1 | Start of a write command |
| byte_vld_i | input | 1 | Incoming byte valid |
| byte_i | input | 8 | Incoming byte |
| wr_end_i | input | 1 | End of the write command |
| bit_res_i | input | 3 | Number of leftover bits at end of command |
| rd_start_i | input | 1 | Restart the readback stream |
| rd_req_i | input | 1 | Request the next readback byte |
| rd_data_o | output | 8 | Readback byte |
| rd_vld_o | output | 1 | Readback byte valid |
| copy_i | input | 1 | Copy request |
| auth_ok_i | input | 1 | Authorization result matches |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W-3 | Memory block index |
| mem_wdata_o | output | 8*BUF_BYTES | Memory write data |
| mem_rdata_i | input | 8*BUF_BYTES | Current contents of the addressed block |

## Verification
The bench builds the block with an 8-bit address, 32-byte pages and page 1 as the write-to-zero page. That gives 32 blocks and 8 pages, so two passes of write, readback and copy can reach every block index, the write-to-zero blocks among them. Because the address is small, the bench can keep a complete expected memory image and compare whole blocks after every copy. The bench also sweeps every bit residue from 0 to 7, and it covers truncated writes, overlong writes, refused copies and readback past the end.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef logic [7:0] byte_t;

  // aa at bit 7, pf at bit 5, all other bits fixed high
  function automatic byte_t mk_status(input logic aa, input logic pf);
    return {aa, 1'b1, pf, 5'b11111};
  endfunction
endpackage

// File: rtl/sp_capture.sv
module sp_capture
  import sp_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  localparam int ALIGN_W = $clog2(BUF_BYTES),
  localparam int CNT_W   = $clog2(BUF_BYTES + 3),
  localparam int BUF_W   = 8 * BUF_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_start_i,
  input  logic             byte_vld_i,
  input  byte_t            byte_i,
  input  logic             wr_end_i,
  input  logic [2:0]       bit_res_i,
  input  logic             accept_i,
  output byte_t            ta_lo_o,
  output byte_t            ta_hi_o,
  output byte_t            status_o,
  output logic [BUF_W-1:0] buf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BUF_BYTES + 2);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q, aa_q, pf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      aa_q    <= 1'b0;
      pf_q    <= 1'b1;
      ta_lo_o <= '0;
      ta_hi_o <= '0;
      buf_o   <= '0;
    end else if (wr_start_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
      aa_q  <= 1'b0;
    end else begin
      if (act_q && byte_vld_i) begin
        if (cnt_q == CNT_W'(0)) ta_lo_o <= {byte_i[7:ALIGN_W], ALIGN_W'(0)};
        if (cnt_q == CNT_W'(1)) ta_hi_o <= byte_i;
        for (int k = 0; k < BUF_BYTES; k++)
          if (cnt_q == CNT_W'(k + 2)) buf_o[8*k +: 8] <= byte_i;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (act_q && wr_end_i) begin
        pf_q  <= (bit_res_i != 3'd0);
        act_q <= 1'b0;
      end
      if (accept_i) aa_q <= 1'b1;
    end
  end

  assign status_o = mk_status(aa_q, pf_q);

  // R4
  aa_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |=> !status_o[7]);
endmodule

// File: rtl/sp_readout.sv
module sp_readout
  import sp_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  localparam int ALIGN_W = $clog2(BUF_BYTES),
  localparam int RD_W    = $clog2(BUF_BYTES + 4),
  localparam int BUF_W   = 8 * BUF_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_start_i,
  input  logic             rd_req_i,
  input  byte_t            ta_lo_i,
  input  byte_t            ta_hi_i,
  input  byte_t            status_i,
  input  logic [BUF_W-1:0] buf_i,
  output byte_t            rd_data_o,
  output logic             rd_vld_o
);
  localparam logic [RD_W-1:0] IDX_END = RD_W'(BUF_BYTES + 3);

  logic [RD_W-1:0] idx_q;
  byte_t           sel;

  always_comb begin
    sel = 8'hFF;
    if (idx_q == RD_W'(0)) sel = ta_lo_i;
    if (idx_q == RD_W'(1)) sel = ta_hi_i;
    if (idx_q == RD_W'(2)) sel = status_i;
    for (int k = 0; k < BUF_BYTES; k++)
      if (idx_q == RD_W'(k + 3)) sel = buf_i[8*k +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      rd_data_o <= '0;
      rd_vld_o  <= 1'b0;
    end else if (rd_start_i) begin
      idx_q    <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      rd_vld_o <= rd_req_i;
      if (rd_req_i) begin
        rd_data_o <= sel;
        if (idx_q != IDX_END) idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R1
  ta_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o && $past(idx_q) == RD_W'(0) |-> rd_data_o[ALIGN_W-1:0] == '0);

  // R2
  status_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o && $past(idx_q) == RD_W'(2) |-> (rd_data_o & 8'h5F) == 8'h5F);
endmodule

// File: rtl/sp_copy.sv
module sp_copy #(
  parameter int BUF_BYTES  = 8,
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 32,
  parameter int WZ_PAGE    = 1,
  localparam int ALIGN_W = $clog2(BUF_BYTES),
  localparam int BLK_W   = ADDR_W - ALIGN_W,
  localparam int PG_SH   = $clog2(PAGE_BYTES) - ALIGN_W,
  localparam int BUF_W   = 8 * BUF_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             copy_i,
  input  logic             auth_ok_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BUF_W-1:0] buf_i,
  input  logic [BUF_W-1:0] mem_rdata_i,
  output logic             accept_o,
  output logic             mem_we_o,
  output logic [BLK_W-1:0] mem_addr_o,
  output logic [BUF_W-1:0] mem_wdata_o
);
  localparam logic [BLK_W-1:0] WZ_PG = BLK_W'(WZ_PAGE);

  logic wz_hit;

  assign mem_addr_o = blk_i;
  assign wz_hit     = (blk_i >> PG_SH) == WZ_PG;
  assign accept_o   = copy_i && auth_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= accept_o;
      if (accept_o) mem_wdata_o <= wz_hit ? (mem_rdata_i & buf_i) : buf_i;
    end
  end

  // R8
  wz_only_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && wz_hit |-> (mem_wdata_o & ~$past(mem_rdata_i)) == '0);
endmodule

// File: rtl/auth_scratchpad.sv
module auth_scratchpad
  import sp_pkg::*;
#(
  parameter int BUF_BYTES  = 8,
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 32,
  parameter int WZ_PAGE    = 1,
  localparam int ALIGN_W = $clog2(BUF_BYTES),
  localparam int BLK_W   = ADDR_W - ALIGN_W,
  localparam int BUF_W   = 8 * BUF_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_start_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             wr_end_i,
  input  logic [2:0]       bit_res_i,
  input  logic             rd_start_i,
  input  logic             rd_req_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_vld_o,
  input  logic             copy_i,
  input  logic             auth_ok_i,
  output logic             mem_we_o,
  output logic [BLK_W-1:0] mem_addr_o,
  output logic [BUF_W-1:0] mem_wdata_o,
  input  logic [BUF_W-1:0] mem_rdata_i
);
  byte_t            ta_lo, ta_hi, status;
  logic [BUF_W-1:0] buf_q;
  logic [15:0]      ta16;
  logic [BLK_W-1:0] blk;
  logic             accept;

  assign ta16 = {ta_hi, ta_lo};
  assign blk  = BLK_W'(ta16 >> ALIGN_W);

  sp_capture #(.BUF_BYTES(BUF_BYTES)) u_cap (
    .clk_i, .rst_ni, .wr_start_i, .byte_vld_i, .byte_i, .wr_end_i, .bit_res_i,
    .accept_i(accept), .ta_lo_o(ta_lo), .ta_hi_o(ta_hi), .status_o(status),
    .buf_o(buf_q)
  );

  sp_readout #(.BUF_BYTES(BUF_BYTES)) u_rd (
    .clk_i, .rst_ni, .rd_start_i, .rd_req_i, .ta_lo_i(ta_lo), .ta_hi_i(ta_hi),
    .status_i(status), .buf_i(buf_q), .rd_data_o, .rd_vld_o
  );

  sp_copy #(
    .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WZ_PAGE(WZ_PAGE)
  ) u_cp (
    .clk_i, .rst_ni, .copy_i, .auth_ok_i, .blk_i(blk), .buf_i(buf_q),
    .mem_rdata_i, .accept_o(accept), .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  // R7
  we_implies_aa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> status[7]);

  // R7
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(copy_i));
endmodule

// File: tb/sim_auth_scratchpad.sv
module sim_auth_scratchpad;
  localparam int NBLK = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 0, byte_vld = 0, wr_end = 0, rd_start = 0, rd_req = 0;
  logic copy = 0, auth = 0;
  logic [7:0] byte_d = 0;
  logic [2:0] bit_res = 0;
  logic [7:0] rd_data;
  logic rd_vld, mem_we;
  logic [4:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [63:0] mem [NBLK];
  logic [63:0] exp_mem [NBLK];
  logic [7:0] wdat [10];
  logic [7:0] rbuf [12];
  logic [7:0] sh_buf [8];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  auth_scratchpad #(.BUF_BYTES(8), .ADDR_W(8), .PAGE_BYTES(32), .WZ_PAGE(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(wr_start), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .wr_end_i(wr_end), .bit_res_i(bit_res), .rd_start_i(rd_start),
    .rd_req_i(rd_req), .rd_data_o(rd_data), .rd_vld_o(rd_vld), .copy_i(copy),
    .auth_ok_i(auth), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] lo, input logic [7:0] hi, input int n,
                          input logic [2:0] res);
    @(negedge clk) wr_start = 1;
    @(negedge clk) wr_start = 0;
    byte_vld = 1; byte_d = lo; @(negedge clk);
    byte_d = hi; @(negedge clk);
    for (int i = 0; i < n; i++) begin
      byte_d = wdat[i];
      if (i < 8) sh_buf[i] = wdat[i];
      @(negedge clk);
    end
    byte_vld = 0; wr_end = 1; bit_res = res;
    @(negedge clk) wr_end = 0; bit_res = 0;
  endtask

  task automatic do_read(input int n);
    @(negedge clk) rd_start = 1;
    @(negedge clk) rd_start = 0;
    for (int i = 0; i < n; i++) begin
      rd_req = 1;
      @(negedge clk) rd_req = 0;
      rbuf[i] = rd_data;
    end
  endtask

  task automatic do_copy(input logic a);
    @(negedge clk) copy = 1; auth = a;
    @(negedge clk) copy = 0; auth = 0;
    @(negedge clk);
  endtask

  function automatic logic [63:0] sh_word();
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = sh_buf[k];
    return w;
  endfunction

  task automatic chk_buf(input string req);
    for (int k = 0; k < 8; k++) chk(req, rbuf[3+k], sh_buf[k]);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBLK; i++) begin mem[i] = '1; exp_mem[i] = '1; end
    for (int k = 0; k < 8; k++) sh_buf[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state: R3 pf=1, R4 aa=0, R5 past end
    do_read(12);
    chk("R1 reset ta_lo", rbuf[0], 8'h00);
    chk("R3 R4 reset status", rbuf[2], 8'h7F);
    chk_buf("R5 reset buffer");
    chk("R5 past end", rbuf[11], 8'hFF);

    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < NBLK; b++) begin
        logic [7:0] lo, hi;
        logic a;
        lo = {b[4:0], b[2:0] ^ 3'b101};
        hi = 8'(b) ^ 8'hA5;
        for (int k = 0; k < 8; k++) wdat[k] = 8'((b * 37 + k * 11 + p * 101 + 3));
        do_write(lo, hi, 8, 3'd0);
        do_read(12);
        chk("R1 ta_lo aligned", rbuf[0], {lo[7:3], 3'b000});
        chk("R5 ta_hi", rbuf[1], hi);
        chk("R2 R3 R4 status after write", rbuf[2], 8'h5F);
        chk_buf("R5 R6 buffer");
        chk("R5 trailing", rbuf[11], 8'hFF);
        a = !(p == 1 && (b % 3) == 0);
        do_copy(a);
        if (a) exp_mem[b] = (b >= 4 && b < 8) ? (exp_mem[b] & sh_word()) : sh_word();
        do_read(3);
        chk("R4 R7 status after copy", rbuf[2], a ? 8'hDF : 8'h5F);
        if (b >= 4 && b < 8) chk("R8 write-to-zero block", mem[b], exp_mem[b]);
        else chk("R7 R9 block", mem[b], exp_mem[b]);
      end
    end
    for (int i = 0; i < NBLK; i++) chk("R7 R9 final image", mem[i], exp_mem[i]);

    // truncated write: 3 whole bytes, 5 stray bits
    for (int k = 0; k < 3; k++) wdat[k] = 8'hC0 + 8'(k);
    do_write(8'h4F, 8'h12, 3, 3'd5);
    do_read(11);
    chk("R1 truncated ta_lo", rbuf[0], 8'h48);
    chk("R3 truncated status", rbuf[2], 8'h7F);
    chk_buf("R6 truncated keeps earlier bytes");

    // residue sweep
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 8; k++) wdat[k] = 8'(r * 16 + k);
      do_write(8'h10, 8'h00, 8, 3'(r));
      do_read(3);
      chk("R3 residue status", rbuf[2], (r == 0) ? 8'h5F : 8'h7F);
    end

    // overlong write, then refused copy into block 2
    for (int k = 0; k < 10; k++) wdat[k] = 8'h60 + 8'(k);
    do_write(8'h17, 8'h00, 10, 3'd0);
    do_read(12);
    chk_buf("R6 extra bytes ignored");
    chk("R5 overlong trailing", rbuf[11], 8'hFF);
    do_copy(1'b0);
    chk("R7 refused copy memory", mem[2], exp_mem[2]);
    do_read(3);
    chk("R7 refused copy status", rbuf[2], 8'h5F);
    do_copy(1'b1);
    chk("R9 authorized copy block 2", mem[2], sh_word());

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule